// File: doc/BRIEF.md
# Startup Output Short Check Sequencer

This block orders the output short test that runs once when an amplifier powers up, before any half-bridge may switch. It leaves every bridge high-impedance and holds the active-low fault line asserted. It then runs two steps in a fixed order. The first step tests every output for a short to ground. The second step tests every output for a short to the supply. While a step runs, the block drives that step's test control high for the analog side. After a programmable settle window it samples the per-output pass flags that come back. When both steps pass, the block releases fault, reports startup complete and lets switching start.

If any output fails a step, the block repeats that step with a new settle window each time the window runs out. It leaves the step only when every output passes, and then goes on to the next step. A device reset is ignored while the test runs. A device reset after completion only gates switching and never starts a new test. Only a power-on reset starts the test again. In the all-single-ended output mode the test is skipped completely.

Top module: `short_check_seq`

## Requirements
- R1: The ground-short step always comes before the supply-short step. `drive_gnd_o` is high exactly during the ground step and `drive_sup_o` exactly during the supply step. The two are never high together.
- R2: Each attempt of a step lasts `settle_i`+1 clock cycles. At the last cycle of the attempt the block samples that step's flags, each delayed by `SYNC_STAGES` clocks. A flag of 1 means the output passed. The step passes only if all `NUM_OUT` flags are 1.
- R3: `fault_n_o` is 0 from power-on reset until the test completes, and 1 afterwards.
- R4: `bridge_en_o` is 0 until the test completes. After that it equals `dev_reset_n`.
- R5: A failed attempt starts a new attempt of the same step, with its drive held high, until an attempt passes. The sequence then continues.
- R6: `dev_reset_n` has no effect on the order or length of the steps while the test runs.
- R7: After completion, a low pulse on `dev_reset_n` does not restart the test. `done_o` stays 1 and neither drive rises.
- R8: With `out_mode_i` = 2'b11 (all single-ended), `done_o` and `fault_n_o` go high one clock after power-on reset is released, and neither drive rises. Modes 2'b00 (two bridged), 2'b01 (one bridged plus two single-ended) and 2'b10 (paralleled) run the test.
- R9: While `rst_n` is low, `done_o`, `fault_n_o`, `bridge_en_o`, `drive_gnd_o` and `drive_sup_o` are all 0.
- R10: After completion, flags that fall to 0 have no effect. `fault_n_o` and `done_o` stay 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, asynchronous, active low; the only trigger of a test |
| dev_reset_n | input | 1 | Device reset, active low; gates switching after completion |
| out_mode_i | input | 2 | Output configuration; 2'b11 = all single-ended (test skipped) |
| settle_i | input | CNT_W | Settle window length minus one, in clocks |
| gnd_ok_i | input | NUM_OUT | Per-output pass flag of the ground-short comparator |
| sup_ok_i | input | NUM_OUT | Per-output pass flag of the supply-short comparator |
| drive_gnd_o | output | 1 | Enables the ground-short test currents |
| drive_sup_o | output | 1 | Enables the supply-short test currents |
| bridge_en_o | output | 1 | Switching permitted; 0 keeps all half-bridges high-impedance |
| fault_n_o | output | 1 | Fault, active low |
| done_o | output | 1 | Startup complete |

## Verification
Every output decodes the registered step state. A drive line therefore changes just after the clock edge that ends an attempt, and `done_o` follows one edge after the last pass. The bench samples on falling edges and counts them from the first edge after reset release. It expects the ground drive on samples 0 to k(S+1)-1, the supply drive on the next j(S+1) samples, and `done_o` right after those.

A flag change made at a given falling edge reaches the step decision three rising edges later. This comes from the two synchronizer stages plus the state register. Retry cases therefore change their flags far enough from a window boundary that the attempt count k or j is exact. The bridge enable is the only combinational path from an input. After completion it is checked one time step after `dev_reset_n` is driven.

// File: rtl/short_check_pkg.sv
package short_check_pkg;

   localparam int MODE_W = 2;
   localparam logic [MODE_W-1:0] MODE_ALL_SE = 2'b11;

   typedef enum logic [1:0] {
      SQ_START = 2'd0,
      SQ_GND   = 2'd1,
      SQ_SUP   = 2'd2,
      SQ_DONE  = 2'd3
   } sq_state_t;

   function automatic logic mode_needs_test(input logic [MODE_W-1:0] m);
      return (m != MODE_ALL_SE);
   endfunction

endpackage

// File: rtl/flag_sync.sv
module flag_sync #(
   parameter int W      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [W-1:0] chain [STAGES];
         always_ff @(posedge clk) begin
            chain[0] <= d;
            for (int k = 1; k < STAGES; k++) chain[k] <= chain[k-1];
         end
         assign q = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] limit,
   output logic             expired
);
   logic [CNT_W-1:0] cnt_q;

   assign expired = run && (cnt_q == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                cnt_q <= '0;
      else if (!run || expired)  cnt_q <= '0;
      else                       cnt_q <= cnt_q + 1'b1;
   end
endmodule

// File: rtl/short_check_seq.sv
module short_check_seq
   import short_check_pkg::*;
#(
   parameter int NUM_OUT     = 4,
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               dev_reset_n,
   input  logic [1:0]         out_mode_i,
   input  logic [CNT_W-1:0]   settle_i,
   input  logic [NUM_OUT-1:0] gnd_ok_i,
   input  logic [NUM_OUT-1:0] sup_ok_i,
   output logic               drive_gnd_o,
   output logic               drive_sup_o,
   output logic               bridge_en_o,
   output logic               fault_n_o,
   output logic               done_o
);
   localparam int FLAG_W = 2 * NUM_OUT;

   initial begin
      assert (NUM_OUT >= 1) else $error("NUM_OUT must be at least 1");
      assert (CNT_W >= 1 && CNT_W <= 24) else $error("CNT_W out of range");
      assert (SYNC_STAGES >= 0 && SYNC_STAGES <= 4) else $error("SYNC_STAGES out of range");
   end

   sq_state_t           state_q, state_d;
   logic [FLAG_W-1:0]   flags_s;
   logic [NUM_OUT-1:0]  gnd_s, sup_s;
   logic                in_step, window_end, step_pass;

   flag_sync #(.W(FLAG_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .d   ({sup_ok_i, gnd_ok_i}),
      .q   (flags_s)
   );
   assign gnd_s = flags_s[NUM_OUT-1:0];
   assign sup_s = flags_s[FLAG_W-1:NUM_OUT];

   assign in_step = (state_q == SQ_GND) || (state_q == SQ_SUP);

   settle_timer #(.CNT_W(CNT_W)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (in_step),
      .limit   (settle_i),
      .expired (window_end)
   );

   assign step_pass = (state_q == SQ_GND) ? (&gnd_s) : (&sup_s);

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         SQ_START: state_d = mode_needs_test(out_mode_i) ? SQ_GND : SQ_DONE;
         SQ_GND:   if (window_end && step_pass) state_d = SQ_SUP;
         SQ_SUP:   if (window_end && step_pass) state_d = SQ_DONE;
         SQ_DONE:  state_d = SQ_DONE;
         default:  state_d = SQ_START;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= SQ_START;
      else        state_q <= state_d;
   end

   assign drive_gnd_o = (state_q == SQ_GND);
   assign drive_sup_o = (state_q == SQ_SUP);
   assign done_o      = (state_q == SQ_DONE);
   assign fault_n_o   = done_o;
   assign bridge_en_o = done_o && dev_reset_n;
endmodule

// File: rtl/short_check_seq_chk.sv
module short_check_seq_chk #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [1:0]       out_mode_i,
   input logic [CNT_W-1:0] settle_i,
   input logic             drive_gnd_o,
   input logic             drive_sup_o,
   input logic             bridge_en_o,
   input logic             fault_n_o,
   input logic             done_o
);
   logic [31:0] gnd_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           gnd_run <= '0;
      else if (drive_gnd_o) gnd_run <= gnd_run + 1;
      else                  gnd_run <= '0;
   end

   AST_STEP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(drive_gnd_o && drive_sup_o)); // R1
   AST_GND_BEFORE_SUP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(drive_sup_o) |-> $past(drive_gnd_o)); // R1
   AST_WINDOW_MULT: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(drive_gnd_o) |-> ((gnd_run % (32'(settle_i) + 32'd1)) == 32'd0)); // R2
   AST_FAULT_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      fault_n_o == done_o); // R3
   AST_HIZ_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      !done_o |-> !bridge_en_o); // R4
   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> done_o); // R7
   AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!drive_gnd_o && !drive_sup_o)); // R10
   AST_SKIP_OR_SUP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_o) |-> ($past(drive_sup_o) || ($past(out_mode_i) == 2'b11))); // R8
endmodule

bind short_check_seq short_check_seq_chk #(.CNT_W(CNT_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .out_mode_i  (out_mode_i),
   .settle_i    (settle_i),
   .drive_gnd_o (drive_gnd_o),
   .drive_sup_o (drive_sup_o),
   .bridge_en_o (bridge_en_o),
   .fault_n_o   (fault_n_o),
   .done_o      (done_o)
);

// File: tb/short_check_seq_tb.sv
module short_check_seq_tb;
   localparam int NUM_OUT = 4;
   localparam int CNT_W   = 8;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               dev_reset_n = 1'b1;
   logic [1:0]         out_mode_i = 2'b00;
   logic [CNT_W-1:0]   settle_i = '0;
   logic [NUM_OUT-1:0] gnd_ok_i = '1;
   logic [NUM_OUT-1:0] sup_ok_i = '1;
   logic drive_gnd_o, drive_sup_o, bridge_en_o, fault_n_o, done_o;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   short_check_seq #(.NUM_OUT(NUM_OUT), .CNT_W(CNT_W), .SYNC_STAGES(2)) u_dut (
      .clk(clk), .rst_n(rst_n), .dev_reset_n(dev_reset_n), .out_mode_i(out_mode_i),
      .settle_i(settle_i), .gnd_ok_i(gnd_ok_i), .sup_ok_i(sup_ok_i),
      .drive_gnd_o(drive_gnd_o), .drive_sup_o(drive_sup_o), .bridge_en_o(bridge_en_o),
      .fault_n_o(fault_n_o), .done_o(done_o)
   );

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // one power-up run; returns measured step lengths and completion sample
   task automatic run_seq(input logic [1:0] mode, input int s, input int gnd_bad, input int sup_bad,
                          input bit toggle_dev, output int lg, output int ls, output int done_at,
                          output int bad_fault, output int bad_bridge);
      lg = 0; ls = 0; done_at = -1; bad_fault = 0; bad_bridge = 0;
      rst_n = 1'b0;
      out_mode_i = mode;
      settle_i = CNT_W'(s);
      gnd_ok_i = (gnd_bad > 0) ? 4'b1011 : 4'b1111;
      sup_ok_i = (sup_bad > 0) ? 4'b1101 : 4'b1111;
      dev_reset_n = 1'b1;
      repeat (4) @(negedge clk);
      chk(!done_o && !fault_n_o && !bridge_en_o && !drive_gnd_o && !drive_sup_o, "R9",
          "outputs in power-on reset", {done_o, fault_n_o, bridge_en_o, drive_gnd_o, drive_sup_o}, 0);
      rst_n = 1'b1;
      for (int i = 0; i < 4000; i++) begin
         @(negedge clk);
         if (done_o) begin done_at = i; break; end
         if (drive_gnd_o) lg++;
         if (drive_sup_o) ls++;
         if (fault_n_o) bad_fault++;
         if (bridge_en_o) bad_bridge++;
         if (i + 1 >= gnd_bad) gnd_ok_i = 4'b1111;
         if (i + 1 >= sup_bad) sup_ok_i = 4'b1111;
         dev_reset_n = toggle_dev ? i[0] : 1'b1;
      end
      dev_reset_n = 1'b1;
   endtask

   // vector: {mode[1:0], settle[7:0]}
   localparam logic [9:0] VEC [0:4] = '{
      {2'b00, 8'd3}, {2'b01, 8'd0}, {2'b10, 8'd5}, {2'b11, 8'd4}, {2'b00, 8'd1}
   };

   initial begin
      #(20 * 150000);
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      int lg, ls, da, bf, bb;
      logic [1:0] m;
      int s, eg;

      foreach (VEC[v]) begin
         m = VEC[v][9:8];
         s = int'(VEC[v][7:0]);
         eg = (m == 2'b11) ? 0 : s + 1;
         run_seq(m, s, 0, 0, 1'b0, lg, ls, da, bf, bb);
         chk(lg == eg, (m == 2'b11) ? "R8" : "R2", "ground step length", lg, eg);
         chk(ls == eg, (m == 2'b11) ? "R8" : "R1", "supply step length", ls, eg);
         chk(da == 2 * eg, (m == 2'b11) ? "R8" : "R1", "completion sample", da, 2 * eg);
         chk(bf == 0, "R3", "fault released early", bf, 0);
         chk(bb == 0, "R4", "bridge enabled early", bb, 0);
         chk(fault_n_o && done_o, "R3", "fault released at done", {fault_n_o, done_o}, 3);
      end

      // R5: ground step fails twice, passes on third attempt
      run_seq(2'b00, 4, 10, 0, 1'b0, lg, ls, da, bf, bb);
      chk(lg == 15, "R5", "ground retry length", lg, 15);
      chk(ls == 5, "R5", "supply after retry", ls, 5);
      chk(bf == 0, "R5", "fault held during retry", bf, 0);

      // R5 / R2: one supply flag low for first attempt only
      run_seq(2'b10, 2, 0, 6, 1'b0, lg, ls, da, bf, bb);
      chk(lg == 3, "R2", "ground length", lg, 3);
      chk(ls == 6, "R5", "supply retry length", ls, 6);
      chk(da == 9, "R5", "completion after supply retry", da, 9);

      // R6: device reset toggling during test
      run_seq(2'b01, 3, 0, 0, 1'b1, lg, ls, da, bf, bb);
      chk(lg == 4 && ls == 4, "R6", "step lengths under device reset", lg + ls, 8);
      chk(da == 8, "R6", "completion under device reset", da, 8);

      // R7 / R10 / R4: after completion
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         gnd_ok_i = '0;
         sup_ok_i = '0;
         dev_reset_n = (k >= 2 && k < 5) ? 1'b0 : 1'b1;
         #1;
         chk(bridge_en_o == dev_reset_n, "R4", "bridge follows device reset", bridge_en_o, dev_reset_n);
         chk(done_o && !drive_gnd_o && !drive_sup_o, "R7", "no restart after device reset",
             {done_o, drive_gnd_o, drive_sup_o}, 4);
         chk(fault_n_o, "R10", "late short ignored", fault_n_o, 1);
      end

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule